// File: doc/BRIEF.md
# Chained-Descriptor Memory Copy Channel

This block is one channel of a memory-to-memory copy engine. Software writes a descriptor pointer and then sets the run bit. The channel then reads a six-word descriptor from memory and copies data one 32-bit word per beat. When the descriptor's byte count is used up, the channel follows the descriptor's link word to the next descriptor. A link equal to the terminator value 0xFFFF_F800 ends the chain. At that point the channel drops its own run bit and pulses a chain-end output.

Each side of the copy can walk through memory or stay on one fixed address, as it would for a peripheral data register. A per-descriptor wait count inserts idle cycles between beats. A pause bit freezes the channel once the beat in progress has finished. Each side has a ready input that holds back that side's requests.

Memory access uses a single word-wide request port. A request is accepted in any cycle in which `mem_ack` is high, and read data is returned in that same cycle. Registers are read through a combinational read port and written with a one-cycle write strobe. Register addresses are byte offsets within the channel's window.

Top module: `dma_chain_channel`

## Requirements
- R1: After reset the run bit, the pause bit and every read-back register read 0, and `mem_req`, `pkg_done` and `queue_end` are low.
- R2: The register map, by byte offset within the channel window:
  - 0x00: run bit (bit 0, read/write).
  - 0x04: pause bit (bit 0, read/write).
  - 0x08: descriptor pointer (read/write, read back exactly as written).
  - 0x0C: current config word (read-only).
  - 0x10: current source address (read-only).
  - 0x14: current destination address (read-only).
  - 0x18: bytes remaining (read-only).
  - 0x1C: current parameter word (read-only).
- R3: When the run bit is set, the channel reads six words from the pointer with bits [1:0] forced to 0, at offsets +0, +4, +8, +12, +16 and +20, in that order. The words are taken as config, source, destination, byte count, parameter and link.
- R4: Each beat reads one word at the current source address and then writes that word to the current destination address. The config word selects how each address moves: bit 5 for the source and bit 21 for the destination. A value of 0 in that bit adds 4 to the address after each beat.
- R5: A value of 1 in the config bit for a side (bit 5 for source, bit 21 for destination) keeps that side's address fixed across all beats.
- R6: Each beat lowers the remaining byte count by 4, stopping at 0. A count that is not a multiple of 4 therefore costs one extra beat. When the count reaches 0, `pkg_done` pulses high for one cycle. A descriptor fetched with a count of 0 moves no data and still pulses `pkg_done`.
- R7: After `pkg_done`, a link other than 0xFFFF_F800 starts a fetch of the next descriptor at that link. A link equal to 0xFFFF_F800 pulses `queue_end` for one cycle, exactly one cycle after `pkg_done`, and the run bit then reads 0.
- R8: Parameter bits [7:0] give N idle cycles between the cycle in which a beat's write is accepted and the next source read request. The next read is therefore accepted N+1 cycles after that write.
- R9: While the pause bit is 1, the channel issues no new fetch or read request. The beat in progress still completes, and all addresses and counts hold until the pause bit is cleared.
- R10: Clearing the run bit stops the channel: from the next cycle on it makes no memory request.
- R11: No source read is requested while `src_rdy` is low, and no destination write is requested while `dst_rdy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| src_rdy | input | 1 | Source side ready for a read |
| dst_rdy | input | 1 | Destination side ready for a write |
| pkg_done | output | 1 | One-cycle pulse when a descriptor's count is exhausted |
| queue_end | output | 1 | One-cycle pulse when the terminator link is reached |

## Verification
The assertions check on every cycle the following properties:
- Each completion pulse lasts one cycle and coincides with a zero remaining count.
- The chain-end pulse follows a completion pulse and leaves the run bit cleared.
- A cleared run bit silences the memory port.
- A paused read phase and a fixed-address side hold their state.

The following can only be shown by the bench's scenarios:
- The exact descriptor fetch order.
- That the copied data lands at the right addresses.
- That the wait count produces the right gap.
- That chaining through a second descriptor works.
- That paused and not-ready channels resume and finish correctly.

// File: rtl/dma_chain_pkg.sv
// Shared constants and types for the chained-descriptor copy channel.
// Assumes a 32-bit word datapath and byte-addressed memory.
package dma_chain_pkg;
    localparam logic [31:0] LINK_END = 32'hFFFF_F800;
    localparam int          DESC_WORDS = 6;

    localparam logic [7:0] OFF_RUN   = 8'h00;
    localparam logic [7:0] OFF_PAUSE = 8'h04;
    localparam logic [7:0] OFF_PTR   = 8'h08;
    localparam logic [7:0] OFF_CFG   = 8'h0C;
    localparam logic [7:0] OFF_SRC   = 8'h10;
    localparam logic [7:0] OFF_DST   = 8'h14;
    localparam logic [7:0] OFF_CNT   = 8'h18;
    localparam logic [7:0] OFF_PAR   = 8'h1C;

    localparam int CFG_SRC_FIXED = 5;
    localparam int CFG_DST_FIXED = 21;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_RD, S_WR, S_WAIT, S_LINK
    } chan_state_t;
endpackage

// File: rtl/dma_chain_regs.sv
// Register window of the channel: run, pause and pointer storage plus the
// read-back mux. Assumes the engine's run-clear request wins over a write.
module dma_chain_regs #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int OW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [OW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          run_clr,
    input  logic [DW-1:0] cur_cfg,
    input  logic [AW-1:0] cur_src,
    input  logic [AW-1:0] cur_dst,
    input  logic [DW-1:0] cur_cnt,
    input  logic [DW-1:0] cur_par,
    output logic          run,
    output logic          pause,
    output logic [AW-1:0] desc_ptr
);
    import dma_chain_pkg::*;

    // Control register updates from software writes and engine completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= 1'b0;
            pause    <= 1'b0;
            desc_ptr <= '0;
        end else begin
            if (reg_wr && reg_addr == OFF_RUN)   run      <= reg_wdata[0];
            if (reg_wr && reg_addr == OFF_PAUSE) pause    <= reg_wdata[0];
            if (reg_wr && reg_addr == OFF_PTR)   desc_ptr <= reg_wdata[AW-1:0];
            if (run_clr)                         run      <= 1'b0;
        end
    end

    // Read-back multiplexer over the channel window.
    always_comb begin
        case (reg_addr)
            OFF_RUN:   reg_rdata = {{(DW-1){1'b0}}, run};
            OFF_PAUSE: reg_rdata = {{(DW-1){1'b0}}, pause};
            OFF_PTR:   reg_rdata = DW'(desc_ptr);
            OFF_CFG:   reg_rdata = cur_cfg;
            OFF_SRC:   reg_rdata = DW'(cur_src);
            OFF_DST:   reg_rdata = DW'(cur_dst);
            OFF_CNT:   reg_rdata = cur_cnt;
            OFF_PAR:   reg_rdata = cur_par;
            default:   reg_rdata = '0;
        endcase
    end

    // R7: an engine run-clear request always leaves the run bit at 0.
    p_run_clr_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_clr |=> !run);
endmodule

// File: rtl/dma_chain_engine.sv
// Descriptor fetch and copy sequencer. Walks a descriptor chain, moving one
// word per beat. Assumes mem_ack completes a request in its cycle.
module dma_chain_engine #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int WAIT_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          pause,
    input  logic [AW-1:0] desc_ptr,
    input  logic          src_rdy,
    input  logic          dst_rdy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          run_clr,
    output logic          pkg_done,
    output logic          queue_end,
    output logic [DW-1:0] cur_cfg,
    output logic [AW-1:0] cur_src,
    output logic [AW-1:0] cur_dst,
    output logic [DW-1:0] cur_cnt,
    output logic [DW-1:0] cur_par
);
    import dma_chain_pkg::*;

    localparam int           BYTES  = DW / 8;
    localparam int           IDX_W  = $clog2(DESC_WORDS);
    localparam logic [DW-1:0] STEP  = DW'(BYTES);
    localparam logic [AW-1:0] ASTEP = AW'(BYTES);

    chan_state_t       st;
    logic [IDX_W-1:0]  widx;
    logic [AW-1:0]     fetch_base;
    logic [AW-1:0]     link;
    logic [DW-1:0]     data_q;
    logic [WAIT_W-1:0] wcnt;
    logic              take;
    logic              last_beat;

    // Request generation per phase; pause and ready inputs gate new requests.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = data_q;
        case (st)
            S_FETCH: begin
                mem_req  = !pause;
                mem_addr = fetch_base + {{(AW-IDX_W-2){1'b0}}, widx, 2'b00};
            end
            S_RD: begin
                mem_req  = !pause && src_rdy;
                mem_addr = cur_src;
            end
            S_WR: begin
                mem_req  = dst_rdy;
                mem_we   = 1'b1;
                mem_addr = cur_dst;
            end
            default: ;
        endcase
    end

    assign take      = mem_req && mem_ack;
    assign last_beat = cur_cnt <= STEP;
    assign run_clr   = (st == S_LINK) && (link == LINK_END);

    // Sequencer: fetch, beat loop with wait gaps, then link or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; widx <= '0; fetch_base <= '0; link <= '0;
            data_q <= '0; wcnt <= '0; pkg_done <= 1'b0; queue_end <= 1'b0;
            cur_cfg <= '0; cur_src <= '0; cur_dst <= '0; cur_cnt <= '0; cur_par <= '0;
        end else begin
            pkg_done  <= 1'b0;
            queue_end <= 1'b0;
            if (!run) begin
                st <= S_IDLE;
            end else begin
                case (st)
                    S_IDLE: begin
                        fetch_base <= {desc_ptr[AW-1:2], 2'b00};
                        widx       <= '0;
                        st         <= S_FETCH;
                    end
                    S_FETCH: if (take) begin
                        case (widx)
                            0: cur_cfg <= mem_rdata;
                            1: cur_src <= mem_rdata[AW-1:0];
                            2: cur_dst <= mem_rdata[AW-1:0];
                            3: cur_cnt <= mem_rdata;
                            4: cur_par <= mem_rdata;
                            default: link <= mem_rdata[AW-1:0];
                        endcase
                        widx <= widx + 1'b1;
                        if (widx == IDX_W'(DESC_WORDS - 1)) begin
                            if (cur_cnt == '0) begin
                                pkg_done <= 1'b1;
                                st       <= S_LINK;
                            end else begin
                                st <= S_RD;
                            end
                        end
                    end
                    S_RD: if (take) begin
                        data_q <= mem_rdata;
                        st     <= S_WR;
                    end
                    S_WR: if (take) begin
                        if (!cur_cfg[CFG_SRC_FIXED]) cur_src <= cur_src + ASTEP;
                        if (!cur_cfg[CFG_DST_FIXED]) cur_dst <= cur_dst + ASTEP;
                        cur_cnt <= last_beat ? '0 : cur_cnt - STEP;
                        if (last_beat) begin
                            pkg_done <= 1'b1;
                            st       <= S_LINK;
                        end else if (cur_par[WAIT_W-1:0] != '0) begin
                            wcnt <= cur_par[WAIT_W-1:0] - 1'b1;
                            st   <= S_WAIT;
                        end else begin
                            st <= S_RD;
                        end
                    end
                    S_WAIT: begin
                        if (wcnt == '0) st <= S_RD;
                        else            wcnt <= wcnt - 1'b1;
                    end
                    S_LINK: begin
                        if (link == LINK_END) begin
                            queue_end <= 1'b1;
                            st        <= S_IDLE;
                        end else begin
                            fetch_base <= {link[AW-1:2], 2'b00};
                            widx       <= '0;
                            st         <= S_FETCH;
                        end
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    // R6: completion pulse is one cycle wide and only with a drained count.
    p_pkg_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pkg_done |=> !pkg_done);
    p_pkg_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pkg_done |-> cur_cnt == '0);
    // R7: chain end directly follows a completion pulse.
    p_end_after_pkg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        queue_end |-> $past(pkg_done));
    // R10: a cleared run bit leaves the memory port idle from the next cycle.
    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mem_req);
    // R9: a paused read phase keeps addresses and count.
    p_pause_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pause && st == S_RD) |=> ($stable(cur_src) && $stable(cur_cnt)));
    // R5: a fixed-address source does not move on a completed write.
    p_src_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack && cur_cfg[CFG_SRC_FIXED]) |=> $stable(cur_src));
endmodule

// File: rtl/dma_chain_channel.sv
// Top of the chained-descriptor copy channel: register window plus engine.
// Assumes one channel per instance and a word-wide single-cycle memory port.
module dma_chain_channel #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int OW = 8,
    parameter int WAIT_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [OW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    input  logic          src_rdy,
    input  logic          dst_rdy,
    output logic          pkg_done,
    output logic          queue_end
);
    logic          run, pause, run_clr;
    logic [AW-1:0] desc_ptr, cur_src, cur_dst;
    logic [DW-1:0] cur_cfg, cur_cnt, cur_par;

    dma_chain_regs #(.AW(AW), .DW(DW), .OW(OW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .run_clr(run_clr),
        .cur_cfg(cur_cfg), .cur_src(cur_src), .cur_dst(cur_dst),
        .cur_cnt(cur_cnt), .cur_par(cur_par), .run(run), .pause(pause),
        .desc_ptr(desc_ptr)
    );

    dma_chain_engine #(.AW(AW), .DW(DW), .WAIT_W(WAIT_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .run(run), .pause(pause), .desc_ptr(desc_ptr),
        .src_rdy(src_rdy), .dst_rdy(dst_rdy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .run_clr(run_clr), .pkg_done(pkg_done),
        .queue_end(queue_end), .cur_cfg(cur_cfg), .cur_src(cur_src),
        .cur_dst(cur_dst), .cur_cnt(cur_cnt), .cur_par(cur_par)
    );

    // R7: the chain-end pulse always coincides with a cleared run bit.
    p_end_clears_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        queue_end |-> !run);
endmodule

// File: tb/tb_dma_chain_channel.sv
module tb_dma_chain_channel;
    localparam logic [31:0] NULL_LINK = 32'hFFFF_F800;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        src_rdy = 1'b1, dst_rdy = 1'b1;
    logic        pkg_done, queue_end;

    logic [31:0] mem [256];
    int errors = 0, checks = 0, cyc = 0;
    int req_n = 0, wr_n = 0, pkg_n = 0, end_n = 0;
    int pkg_cyc = 0, end_cyc = 0, wr_cyc = 0, gap = 0;
    logic [31:0] alog [64];

    dma_chain_channel dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .src_rdy(src_rdy),
        .dst_rdy(dst_rdy), .pkg_done(pkg_done), .queue_end(queue_end)
    );

    always #10 clk = ~clk;
    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_ack && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end

    // Observer of accepted requests and pulses, sampled mid-cycle.
    always @(negedge clk) begin
        if (mem_req && mem_ack) begin
            alog[req_n % 64] <= mem_addr;
            req_n <= req_n + 1;
            if (mem_we) begin
                wr_n   <= wr_n + 1;
                wr_cyc <= cyc;
            end else if (mem_addr >= 32'h200) begin
                gap <= cyc - wr_cyc;
            end
        end
        if (pkg_done)  begin pkg_n <= pkg_n + 1; pkg_cyc <= cyc; end
        if (queue_end) begin end_n <= end_n + 1; end_cyc <= cyc; end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic put_desc(input logic [31:0] base, input logic [31:0] cfg,
            input logic [31:0] s, input logic [31:0] d, input logic [31:0] n,
            input logic [31:0] p, input logic [31:0] lk);
        mem[base[9:2]]     = cfg; mem[base[9:2] + 1] = s;
        mem[base[9:2] + 2] = d;   mem[base[9:2] + 3] = n;
        mem[base[9:2] + 4] = p;   mem[base[9:2] + 5] = lk;
    endtask

    task automatic wait_end(input int e0);
        for (int i = 0; i < 3000 && end_n == e0; i++) @(negedge clk);
        chk(end_n == e0 + 1, "R7 chain end reached", end_n, e0 + 1);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int o = 0; o < 8; o++) begin
            rd_reg(8'(o * 4), v);
            chk(v == 0, "R1 register reset value", v, 0);
        end
        chk(!mem_req && !pkg_done && !queue_end, "R1 outputs idle",
            {mem_req, pkg_done, queue_end}, 0);
    endtask

    task automatic t_single;
        logic [31:0] v;
        int r0 = req_n, e0 = end_n, p0 = pkg_n;
        for (int i = 0; i < 4; i++) mem[(32'h200 >> 2) + i] = 32'hA000_0000 + i;
        put_desc(32'h100, 32'h0000_0000, 32'h200, 32'h300, 16, 0, NULL_LINK);
        wr_reg(8'h08, 32'h102);
        rd_reg(8'h08, v);
        chk(v == 32'h102, "R2 pointer read back", v, 32'h102);
        wr_reg(8'h00, 1);
        wait_end(e0);
        for (int i = 0; i < 6; i++)
            chk(alog[(r0 + i) % 64] == 32'h100 + 4 * i, "R3 fetch order",
                alog[(r0 + i) % 64], 32'h100 + 4 * i);
        for (int i = 0; i < 4; i++)
            chk(mem[(32'h300 >> 2) + i] == 32'hA000_0000 + i, "R4 copied word",
                mem[(32'h300 >> 2) + i], 32'hA000_0000 + i);
        rd_reg(8'h10, v); chk(v == 32'h210, "R4 source advanced", v, 32'h210);
        rd_reg(8'h14, v); chk(v == 32'h310, "R4 destination advanced", v, 32'h310);
        rd_reg(8'h18, v); chk(v == 0, "R6 count drained", v, 0);
        rd_reg(8'h00, v); chk(v == 0, "R7 run bit cleared", v, 0);
        chk(pkg_n == p0 + 1, "R6 one completion pulse", pkg_n, p0 + 1);
        chk(end_cyc == pkg_cyc + 1, "R7 end one cycle after completion",
            end_cyc, pkg_cyc + 1);
        chk(gap == 1, "R8 zero wait gap", gap, 1);
    endtask

    task automatic t_fixed;
        logic [31:0] v;
        int e0 = end_n, w0 = wr_n;
        mem[32'h280 >> 2] = 32'h5A5A_1234;
        put_desc(32'h100, 32'h0000_0020, 32'h280, 32'h380, 10, 0, NULL_LINK);
        wr_reg(8'h08, 32'h100);
        wr_reg(8'h00, 1);
        wait_end(e0);
        chk(wr_n == w0 + 3, "R6 odd count rounds up to 3 beats", wr_n, w0 + 3);
        for (int i = 0; i < 3; i++)
            chk(mem[(32'h380 >> 2) + i] == 32'h5A5A_1234, "R5 fixed source data",
                mem[(32'h380 >> 2) + i], 32'h5A5A_1234);
        rd_reg(8'h10, v); chk(v == 32'h280, "R5 source held", v, 32'h280);
        rd_reg(8'h0C, v); chk(v == 32'h20, "R2 config read back", v, 32'h20);
    endtask

    task automatic t_dst_fixed;
        logic [31:0] v;
        int e0 = end_n;
        mem[32'h240 >> 2] = 32'h1111_0001; mem[(32'h240 >> 2) + 1] = 32'h1111_0002;
        put_desc(32'h100, 32'h0020_0000, 32'h240, 32'h3C0, 8, 0, NULL_LINK);
        wr_reg(8'h08, 32'h100);
        wr_reg(8'h00, 1);
        wait_end(e0);
        rd_reg(8'h14, v); chk(v == 32'h3C0, "R5 destination held", v, 32'h3C0);
        chk(mem[32'h3C0 >> 2] == 32'h1111_0002, "R5 last word at fixed destination",
            mem[32'h3C0 >> 2], 32'h1111_0002);
    endtask

    task automatic t_chain;
        logic [31:0] v;
        int e0 = end_n, p0 = pkg_n, w0 = wr_n;
        mem[32'h200 >> 2] = 32'hC0DE_0001; mem[(32'h200 >> 2) + 1] = 32'hC0DE_0002;
        put_desc(32'h100, 32'h0, 32'h200, 32'h340, 8, 0, 32'h140);
        put_desc(32'h140, 32'h0000_00AB, 32'h200, 32'h3E0, 0, 0, NULL_LINK);
        wr_reg(8'h08, 32'h100);
        wr_reg(8'h00, 1);
        wait_end(e0);
        chk(pkg_n == p0 + 2, "R7 two descriptors completed", pkg_n, p0 + 2);
        chk(wr_n == w0 + 2, "R6 zero-count descriptor moves nothing", wr_n, w0 + 2);
        chk(mem[(32'h340 >> 2) + 1] == 32'hC0DE_0002, "R7 first descriptor copied",
            mem[(32'h340 >> 2) + 1], 32'hC0DE_0002);
        rd_reg(8'h0C, v); chk(v == 32'hAB, "R7 second descriptor loaded", v, 32'hAB);
    endtask

    task automatic t_wait;
        logic [31:0] v;
        int e0 = end_n;
        put_desc(32'h100, 32'h0, 32'h200, 32'h340, 8, 3, NULL_LINK);
        wr_reg(8'h08, 32'h100);
        wr_reg(8'h00, 1);
        wait_end(e0);
        chk(gap == 4, "R8 three wait cycles", gap, 4);
        rd_reg(8'h1C, v); chk(v == 3, "R2 parameter read back", v, 3);
    endtask

    task automatic t_pause;
        logic [31:0] c1, c2;
        int e0 = end_n, w0 = wr_n, w1;
        put_desc(32'h100, 32'h0, 32'h200, 32'h300, 32, 5, NULL_LINK);
        wr_reg(8'h08, 32'h100);
        wr_reg(8'h00, 1);
        for (int i = 0; i < 200 && wr_n == w0; i++) @(negedge clk);
        wr_reg(8'h04, 1);
        repeat (20) @(negedge clk);
        w1 = wr_n;
        rd_reg(8'h18, c1);
        repeat (20) @(negedge clk);
        rd_reg(8'h18, c2);
        chk(wr_n == w1, "R9 no beats while paused", wr_n, w1);
        chk(c1 == c2, "R9 count held while paused", c2, c1);
        chk(w1 - w0 < 8, "R9 paused before finishing", w1 - w0, 8);
        wr_reg(8'h04, 0);
        wait_end(e0);
        chk(wr_n == w0 + 8, "R9 all beats after resume", wr_n, w0 + 8);
    endtask

    task automatic t_halt;
        logic [31:0] v;
        int w0 = wr_n, r1;
        put_desc(32'h100, 32'h0, 32'h200, 32'h300, 64, 10, NULL_LINK);
        wr_reg(8'h08, 32'h100);
        wr_reg(8'h00, 1);
        for (int i = 0; i < 200 && wr_n == w0; i++) @(negedge clk);
        wr_reg(8'h00, 0);
        r1 = req_n;
        repeat (40) @(negedge clk);
        chk(req_n == r1, "R10 no requests after halt", req_n, r1);
        rd_reg(8'h00, v); chk(v == 0, "R10 run bit reads 0", v, 0);
    endtask

    task automatic t_ready;
        int e0 = end_n, r0 = req_n, w0 = wr_n;
        src_rdy = 1'b0;
        put_desc(32'h100, 32'h0, 32'h200, 32'h300, 8, 0, NULL_LINK);
        wr_reg(8'h08, 32'h100);
        wr_reg(8'h00, 1);
        repeat (20) @(negedge clk);
        chk(req_n == r0 + 6, "R11 only fetches while source not ready", req_n, r0 + 6);
        src_rdy = 1'b1; dst_rdy = 1'b0;
        repeat (10) @(negedge clk);
        chk(wr_n == w0, "R11 no write while destination not ready", wr_n, w0);
        dst_rdy = 1'b1;
        wait_end(e0);
        chk(wr_n == w0 + 2, "R11 beats finish once ready", wr_n, w0 + 2);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_single;
        t_fixed;
        t_dst_fixed;
        t_chain;
        t_wait;
        t_pause;
        t_halt;
        t_ready;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule